// File: doc/BRIEF.md
# Typed Memory-Mapped Register Cell

This block is one register of a register bank. It sits between a bus-side controller, which issues single-cycle read and write requests with an address, and a piece of functional logic, which both supplies a value to the register and consumes its current contents. The cell compares the request address with its own address, given as a parameter. It then applies the access rules of its type, also a parameter, and reports whether each access was accepted.

Five types exist. A read-only cell mirrors the functional input. Write-only and read/write cells are loaded by the bus only. A clear-on-read cell collects event bits from the functional side and empties itself when the bus reads it. A constant cell always holds a parameter value. The bus request pins have no back-pressure. A request is a one-cycle pulse that is always taken. The response comes back on the next clock edge as a one-cycle pulse: `dout_valid` for an accepted read and `din_ack` for an accepted write. A request that the type rejects gives no pulse.

Top module: `typed_reg_cell`

## Requirements
- R1: `reg_chosen` is high in the same cycle exactly when `addr` equals the `REG_ADDR` parameter.
- R2: `din_ack` and `dout_valid` are raised only in the cycle after a write (or read) request whose address matched.
- R3: A matched read on a RO, RW, COR or CONST cell raises `dout_valid` one cycle later, with the register contents on `dout` in that same cycle. A matched read on a WO cell leaves `dout_valid` low.
- R4: A matched write on a WO or RW cell loads `din`, so `reg_val` shows it one cycle later, and it raises `din_ack` in that same cycle. Writes on consecutive cycles each load and are each acknowledged.
- R5: A write on a RO, COR or CONST cell raises no `din_ack` and does not alter the contents.
- R6: WO and RW cells ignore `reg_in_b`. They change only on an accepted write.
- R7: A RO cell loads `reg_in_b` on every clock, so `reg_val` equals the previous cycle's `reg_in_b`.
- R8: A COR cell ORs `reg_in_b` into its contents on every clock. An accepted read clears the contents to zero.
- R9: When a COR read and nonzero `reg_in_b` coincide, `dout` returns the stored bits ORed with that `reg_in_b`, and the cell is still zero afterwards.
- R10: A CONST cell shows `CONST_VAL` on `reg_val` at all times, including during reset.
- R11: While the synchronous active-high `rst` is high, `din_ack` and `dout_valid` are low and the contents are zero. CONST is the exception, and keeps `CONST_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Request address |
| wr_en | input | 1 | Write request pulse |
| rd_en | input | 1 | Read request pulse |
| din | input | DATA_W | Write data from the bus side |
| reg_in_b | input | DATA_W | Value from the functional logic |
| dout | output | DATA_W | Read data, meaningful while `dout_valid` is high |
| din_ack | output | 1 | Write accepted, one cycle after the request |
| dout_valid | output | 1 | Read accepted, one cycle after the request |
| reg_chosen | output | 1 | Address match, combinational |
| reg_val | output | DATA_W | Current contents toward the functional logic |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high together. A simultaneous read and write is not one of the defined cases. They also assume that every request lasts exactly one cycle. The stimulus holds to both rules: each cycle carries a write, a read, or neither, and the phase with random values draws from those three choices only. Within those limits the stimulus picks addresses that mostly hit the cell and sometimes miss it. It also puts functional values on `reg_in_b` during reads, so that the clear-on-read capture case occurs many times.

// File: rtl/treg_pkg.sv
package treg_pkg;
  typedef enum logic [2:0] {
    KIND_RO    = 3'd0,
    KIND_WO    = 3'd1,
    KIND_RW    = 3'd2,
    KIND_COR   = 3'd3,
    KIND_CONST = 3'd4
  } reg_kind_e;

  function automatic bit kind_readable(reg_kind_e k);
    return k != KIND_WO;
  endfunction

  function automatic bit kind_writable(reg_kind_e k);
    return (k == KIND_WO) || (k == KIND_RW);
  endfunction
endpackage

// File: rtl/treg_decode.sv
module treg_decode
  import treg_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'hA,
  parameter reg_kind_e         KIND     = KIND_RW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              sel,
  output logic              rd_ok,
  output logic              wr_ok
);
  localparam bit READABLE = kind_readable(KIND);
  localparam bit WRITABLE = kind_writable(KIND);

  always_comb begin
    sel   = (addr == REG_ADDR);
    rd_ok = sel && rd_en && READABLE;
    wr_ok = sel && wr_en && WRITABLE;
  end
endmodule

// File: rtl/treg_store.sv
module treg_store
  import treg_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter reg_kind_e         KIND      = KIND_RW,
  parameter logic [DATA_W-1:0] CONST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] reg_in_b,
  output logic [DATA_W-1:0] val_q,
  output logic [DATA_W-1:0] rd_data
);
  generate
    if (KIND == KIND_RO) begin : g_ro
      logic unused_ro;
      assign unused_ro = ^{din, wr_ok, rd_ok};
      always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= reg_in_b;
      end
      assign rd_data = val_q;
    end else if (KIND == KIND_WO || KIND == KIND_RW) begin : g_bus
      logic unused_bus;
      assign unused_bus = ^{reg_in_b, rd_ok};
      always_ff @(posedge clk) begin
        if (rst)        val_q <= '0;
        else if (wr_ok) val_q <= din;
      end
      assign rd_data = val_q;

      AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> val_q == $past(din)); // R4
      AST_BUS_ONLY: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(val_q)); // R6
    end else if (KIND == KIND_COR) begin : g_cor
      logic unused_cor;
      assign unused_cor = ^{din, wr_ok};
      always_ff @(posedge clk) begin
        if (rst)        val_q <= '0;
        else if (rd_ok) val_q <= '0;
        else            val_q <= val_q | reg_in_b;
      end
      assign rd_data = val_q | reg_in_b;

      AST_COR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_ok |=> val_q == '0); // R8
      AST_COR_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rd_ok |=> (val_q & $past(val_q)) == $past(val_q)); // R8
    end else begin : g_const
      logic unused_const;
      assign unused_const = ^{clk, rst, din, reg_in_b, wr_ok, rd_ok};
      assign val_q   = CONST_VAL;
      assign rd_data = CONST_VAL;
    end
  endgenerate
endmodule

// File: rtl/treg_resp.sv
module treg_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              din_ack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= '0;
      dout_valid <= 1'b0;
      din_ack    <= 1'b0;
    end else begin
      dout_valid <= rd_ok;
      din_ack    <= wr_ok;
      if (rd_ok) dout <= rd_data;
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    !(dout_valid && din_ack)); // R2
endmodule

// File: rtl/typed_reg_cell.sv
module typed_reg_cell
  import treg_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 4'hA,
  parameter reg_kind_e         KIND      = KIND_RW,
  parameter logic [DATA_W-1:0] CONST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] reg_in_b,
  output logic [DATA_W-1:0] dout,
  output logic              din_ack,
  output logic              dout_valid,
  output logic              reg_chosen,
  output logic [DATA_W-1:0] reg_val
);
  localparam bit READABLE = kind_readable(KIND);
  localparam bit WRITABLE = kind_writable(KIND);

  logic              sel, rd_ok, wr_ok;
  logic [DATA_W-1:0] rd_data;

  treg_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .KIND(KIND)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .sel(sel), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  treg_store #(.DATA_W(DATA_W), .KIND(KIND), .CONST_VAL(CONST_VAL)) u_store (
    .clk(clk), .rst(rst), .rd_ok(rd_ok), .wr_ok(wr_ok),
    .din(din), .reg_in_b(reg_in_b), .val_q(reg_val), .rd_data(rd_data)
  );

  treg_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .rd_ok(rd_ok), .wr_ok(wr_ok), .rd_data(rd_data),
    .dout(dout), .dout_valid(dout_valid), .din_ack(din_ack)
  );

  assign reg_chosen = sel;

  AST_ACK_MATCHED: assert property (@(posedge clk) disable iff (rst)
    din_ack |-> $past(wr_en && addr == REG_ADDR)); // R2
  AST_VALID_MATCHED: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $past(rd_en && addr == REG_ADDR)); // R2

  generate
    if (!WRITABLE) begin : g_no_wr
      AST_NO_WRITE_ACK: assert property (@(posedge clk) disable iff (rst)
        !din_ack); // R5
    end
    if (!READABLE) begin : g_no_rd
      AST_NO_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        !dout_valid); // R3
    end
    if (KIND == KIND_CONST) begin : g_const_chk
      AST_CONST_HELD: assert property (@(posedge clk)
        reg_val == CONST_VAL); // R10
    end
  endgenerate
endmodule

// File: tb/typed_reg_cell_test.sv
`timescale 1ns/100ps
module typed_reg_cell_test;
  import treg_pkg::*;

  localparam int NK = 5;
  localparam logic [3:0] MY_ADDR = 4'hA;
  localparam logic [7:0] CVAL = 8'h5C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] din = '0, rib = '0;

  logic [7:0] dout_a [NK];
  logic [7:0] val_a  [NK];
  logic       ack_a  [NK];
  logic       dv_a   [NK];
  logic       ch_a   [NK];

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int mval  [NK];
  int mdout [NK];
  bit mdv   [NK];
  bit mack  [NK];
  bit prev_sel = 0;
  bit prev_rst = 1;

  always #2.5 clk = ~clk;

  typed_reg_cell #(.REG_ADDR(MY_ADDR), .KIND(KIND_RO)) uut_ro (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .din(din), .reg_in_b(rib),
    .dout(dout_a[0]), .din_ack(ack_a[0]), .dout_valid(dv_a[0]), .reg_chosen(ch_a[0]), .reg_val(val_a[0]));
  typed_reg_cell #(.REG_ADDR(MY_ADDR), .KIND(KIND_WO)) uut_wo (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .din(din), .reg_in_b(rib),
    .dout(dout_a[1]), .din_ack(ack_a[1]), .dout_valid(dv_a[1]), .reg_chosen(ch_a[1]), .reg_val(val_a[1]));
  typed_reg_cell #(.REG_ADDR(MY_ADDR), .KIND(KIND_RW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .din(din), .reg_in_b(rib),
    .dout(dout_a[2]), .din_ack(ack_a[2]), .dout_valid(dv_a[2]), .reg_chosen(ch_a[2]), .reg_val(val_a[2]));
  typed_reg_cell #(.REG_ADDR(MY_ADDR), .KIND(KIND_COR)) uut_cor (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .din(din), .reg_in_b(rib),
    .dout(dout_a[3]), .din_ack(ack_a[3]), .dout_valid(dv_a[3]), .reg_chosen(ch_a[3]), .reg_val(val_a[3]));
  typed_reg_cell #(.REG_ADDR(MY_ADDR), .KIND(KIND_CONST), .CONST_VAL(CVAL)) uut_const (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .din(din), .reg_in_b(rib),
    .dout(dout_a[4]), .din_ack(ack_a[4]), .dout_valid(dv_a[4]), .reg_chosen(ch_a[4]), .reg_val(val_a[4]));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model; runs at a falling edge.
  task automatic compare();
    for (int k = 0; k < NK; k++) begin
      string ack_tag, dv_tag, val_tag;
      chk($sformatf("R1 reg_chosen cell%0d", k), ch_a[k], addr == MY_ADDR);
      if (prev_rst)       begin ack_tag = "R11"; dv_tag = "R11"; end
      else if (!prev_sel) begin ack_tag = "R2";  dv_tag = "R2";  end
      else begin
        ack_tag = (k == 1 || k == 2) ? "R4" : "R5";
        dv_tag  = "R3";
      end
      chk($sformatf("%s din_ack cell%0d", ack_tag, k), ack_a[k], mack[k]);
      chk($sformatf("%s dout_valid cell%0d", dv_tag, k), dv_a[k], mdv[k]);
      if (mdv[k])
        chk($sformatf("%s dout cell%0d", (k == 3) ? "R9" : "R3", k), dout_a[k], mdout[k]);
      case (k)
        0: val_tag = "R7";
        1, 2: val_tag = "R6";
        3: val_tag = "R8";
        default: val_tag = "R10";
      endcase
      if (prev_rst && k != 4) val_tag = "R11";
      chk($sformatf("%s reg_val cell%0d", val_tag, k), val_a[k], mval[k]);
    end
  endtask

  // Advance the model with the inputs that the next rising edge samples.
  task automatic model_edge();
    bit s;
    s = (addr == MY_ADDR);
    for (int k = 0; k < NK; k++) begin
      bit rdok, wrok;
      if (rst) begin
        mval[k] = (k == 4) ? int'(CVAL) : 0;
        mdv[k]  = 0;
        mack[k] = 0;
        mdout[k] = 0;
        continue;
      end
      rdok = s && rd_en && (k != 1);
      wrok = s && wr_en && (k == 1 || k == 2);
      mdv[k]  = rdok;
      mack[k] = wrok;
      if (rdok) mdout[k] = (k == 3) ? (mval[k] | int'(rib)) : mval[k];
      case (k)
        0: mval[k] = int'(rib);
        1, 2: if (wrok) mval[k] = int'(din);
        3: mval[k] = rdok ? 0 : (mval[k] | int'(rib));
        default: mval[k] = int'(CVAL);
      endcase
    end
    prev_sel = s;
    prev_rst = rst;
  endtask

  task automatic step(logic r, logic [3:0] a, logic w, logic rd, logic [7:0] d, logic [7:0] b);
    @(negedge clk);
    compare();
    rst = r; addr = a; wr_en = w; rd_en = rd; din = d; rib = b;
    model_edge();
  endtask

  initial begin
    for (int k = 0; k < NK; k++) begin
      mval[k] = (k == 4) ? int'(CVAL) : 0;
      mdout[k] = 0; mdv[k] = 0; mack[k] = 0;
    end
    // Reset with busy inputs: outputs stay low (R11)
    step(1, MY_ADDR, 1, 0, 8'hFF, 8'h3C);
    step(1, MY_ADDR, 0, 1, 8'hFF, 8'h3C);
    step(1, 4'h0, 0, 0, 8'h00, 8'h00);
    // R1/R2: miss address, no responses
    step(0, 4'h3, 1, 0, 8'h11, 8'h00);
    step(0, 4'h3, 0, 1, 8'h00, 8'h00);
    // R4: back-to-back writes, each acked
    step(0, MY_ADDR, 1, 0, 8'h07, 8'h00);
    step(0, MY_ADDR, 1, 0, 8'h08, 8'h00);
    // R6: functional input ignored by bus-only cells
    step(0, 4'h0, 0, 0, 8'h00, 8'hA5);
    // R3: read everything
    step(0, MY_ADDR, 0, 1, 8'h00, 8'h00);
    // R8: accumulate COR bits
    step(0, 4'h0, 0, 0, 8'h00, 8'h04);
    step(0, 4'h0, 0, 0, 8'h00, 8'h01);
    // R9: read with concurrent update
    step(0, MY_ADDR, 0, 1, 8'h00, 8'h10);
    step(0, 4'h0, 0, 0, 8'h00, 8'h00);
    // R5: write to read-only types
    step(0, MY_ADDR, 1, 0, 8'hEE, 8'h20);
    step(0, MY_ADDR, 0, 1, 8'h00, 8'h00);
    step(0, 4'hF, 0, 1, 8'h00, 8'h00);
    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [3:0] a;
      op = $urandom_range(0, 2);
      a  = ($urandom_range(0, 3) != 0) ? MY_ADDR : 4'($urandom_range(0, 15));
      step(($urandom_range(0, 499) == 0) ? 1'b1 : 1'b0, a, op == 1, op == 2,
           8'($urandom_range(0, 255)),
           ($urandom_range(0, 2) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00);
    end
    step(0, 4'h0, 0, 0, 8'h00, 8'h00);
    step(0, 4'h0, 0, 0, 8'h00, 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule